// File: doc/BRIEF.md
# Multi-core address-range write monitor

This block sits beside a shared memory and lets each of several cores wait idly until some other agent writes to a small region it cares about. A core first loads a watch range, which spans one 64-byte line starting at a physical address. It then arms the watch. Every write request seen on the snoop port, given as a start address and a byte length, is compared against every armed range in the same cycle. Each core whose armed range overlaps the write gets a one-cycle wake pulse, and its watch is disarmed.

A core can also drop its watch without a write, for example when an interrupt has already woken it. The block keeps a count of armed watches. While that count is zero, no comparison is made and no hit is reported. A separate combinational page port reports whether a 4 KiB page holds any armed range. A write-path shortcut can then be refused for that page, while reads pass freely.

Top module: `wr_range_watch`

## Requirements
- R1: After reset, no core is armed, the armed count is 0, and the wake, clear and veto outputs are low. Every range holds begin = end = all ones, so an arm request issued before any setup leaves the core unarmed.
- R2: A setup pulse on core i loads begin = setup address and end = setup address + 64, modulo 2^AW. This is allowed while the core is armed and keeps it armed. A setup address within the last 64 bytes of the space gives end below begin, which is illegal and is flagged.
- R3: A write of len bytes at address a overlaps a range [begin, end) unless a >= end or a + len <= begin. The sum a + len is taken without wrap.
- R4: An arm request on an unarmed core with begin != end arms it and raises the count by one. Arming an already armed core changes neither the core nor the count. The count always equals the number of armed cores.
- R5: A snooped write that overlaps an armed core's range produces, in the cycle after the write, a one-cycle pulse on that core's wake and monitor-clear outputs. The core is no longer armed and the count drops by one.
- R6: Unarmed cores never wake. While the count is 0, writes produce no wake.
- R7: A disarm request on an armed core clears it, pulses monitor-clear without wake, and lowers the count. When disarm and arm arrive together on one core, disarm wins.
- R8: The page veto output is high only when the page query is a write (pg_wr = 1) and the 4 KiB page holding pg_addr, i.e. [pg_addr with its low 12 bits cleared, +4096), overlaps an armed range. A read query never vetoes.
- R9: All cores are checked in parallel, so one write overlapping several armed ranges wakes all of them in the same cycle, and the count drops by their number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_vld | input | NCORE | Per-core range setup strobe |
| setup_addr | input | NCORE*AW | Per-core physical start address, core i in bits [i*AW +: AW] |
| arm_req | input | NCORE | Per-core arm request |
| disarm_req | input | NCORE | Per-core disarm request |
| wr_vld | input | 1 | Write snoop valid |
| wr_addr | input | AW | Write start address |
| wr_len | input | LENW | Write length in bytes |
| pg_addr | input | AW | Page query address |
| pg_wr | input | 1 | Page query is a write access |
| wake_o | output | NCORE | Per-core wake pulse |
| mon_clr_o | output | NCORE | Per-core monitor-cleared pulse |
| mon_active_o | output | NCORE | Per-core armed flag |
| active_cnt_o | output | $clog2(NCORE+1) | Number of armed cores |
| pg_veto_o | output | 1 | Write access to the queried page must be refused |

## Verification
The bench builds the block with NCORE = 4, AW = 16 and LENW = 8. The 16-bit address space lets a range sit just below the top of memory. A write can then end past 2^AW, which exercises the unwrapped write-end comparison. Four cores are enough to place overlapping ranges on neighbouring lines so that one write wakes two cores at once. A fourth range lies in its own page for the veto queries, and disarm-versus-arm priority can be tested on it.

// File: rtl/wrw_pkg.sv
package wrw_pkg;

  localparam int PAGE_SHIFT = 12;

  // Half-open interval intersection on zero-extended operands.
  function automatic logic spans_meet(input logic [63:0] a_lo, input logic [63:0] a_hi,
                                      input logic [63:0] b_lo, input logic [63:0] b_hi);
    return !((a_lo >= b_hi) || (a_hi <= b_lo));
  endfunction

endpackage

// File: rtl/wrw_slot.sv
module wrw_slot #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          setup_vld,
  input  logic [AW-1:0] setup_addr,
  input  logic          arm,
  input  logic          disarm,
  input  logic          chk_en,
  input  logic          wr_vld,
  input  logic [AW:0]   wr_lo,
  input  logic [AW:0]   wr_hi,
  input  logic [AW:0]   pg_lo,
  input  logic [AW:0]   pg_hi,
  output logic          active,
  output logic          set_ev,
  output logic          clr_ev,
  output logic          wake,
  output logic          clr_pulse,
  output logic          pg_hit,
  output logic [AW-1:0] rng_lo,
  output logic [AW-1:0] rng_hi
);
  import wrw_pkg::*;

  localparam logic [AW-1:0] LINE_INC = AW'(LINE_BYTES);

  logic [AW-1:0] beg_q, end_q, beg_d, end_d;
  logic          act_q, act_d, wake_q, clr_q, hit_c;

  always_comb begin
    hit_c  = chk_en & wr_vld & act_q &
             spans_meet(64'(wr_lo), 64'(wr_hi), 64'(beg_q), 64'(end_q));
    clr_ev = act_q & (hit_c | disarm);
    set_ev = ~act_q & arm & ~disarm & (beg_q != end_q);
    act_d  = (act_q & ~clr_ev) | set_ev;
    beg_d  = setup_addr;
    end_d  = setup_addr + LINE_INC;
    pg_hit = chk_en & act_q &
             spans_meet(64'(pg_lo), 64'(pg_hi), 64'(beg_q), 64'(end_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beg_q <= '1;
      end_q <= '1;
    end else if (setup_vld) begin
      beg_q <= beg_d;
      end_q <= end_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wake_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      wake_q <= hit_c;
      clr_q  <= clr_ev;
    end
  end

  assign active    = act_q;
  assign wake      = wake_q;
  assign clr_pulse = clr_q;
  assign rng_lo    = beg_q;
  assign rng_hi    = end_q;

endmodule

// File: rtl/wrw_count.sv
module wrw_count #(
  parameter int NCORE = 4,
  parameter int CW    = $clog2(NCORE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] set_vec,
  input  logic [NCORE-1:0] clr_vec,
  output logic [CW-1:0]    cnt
);
  logic [CW-1:0] cnt_q, cnt_d, n_set, n_clr;

  always_comb begin
    n_set = '0;
    n_clr = '0;
    for (int i = 0; i < NCORE; i++) begin
      n_set = n_set + CW'(set_vec[i]);
      n_clr = n_clr + CW'(clr_vec[i]);
    end
    cnt_d = cnt_q + n_set - n_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/wr_range_watch.sv
module wr_range_watch #(
  parameter int NCORE      = 4,
  parameter int AW         = 32,
  parameter int LENW       = 8,
  parameter int LINE_BYTES = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NCORE-1:0]             setup_vld,
  input  logic [NCORE*AW-1:0]          setup_addr,
  input  logic [NCORE-1:0]             arm_req,
  input  logic [NCORE-1:0]             disarm_req,
  input  logic                         wr_vld,
  input  logic [AW-1:0]                wr_addr,
  input  logic [LENW-1:0]              wr_len,
  input  logic [AW-1:0]                pg_addr,
  input  logic                         pg_wr,
  output logic [NCORE-1:0]             wake_o,
  output logic [NCORE-1:0]             mon_clr_o,
  output logic [NCORE-1:0]             mon_active_o,
  output logic [$clog2(NCORE+1)-1:0]   active_cnt_o,
  output logic                         pg_veto_o
);
  import wrw_pkg::*;

  localparam int CW = $clog2(NCORE + 1);
  localparam logic [AW:0] PAGE_SPAN = (AW+1)'(1) << PAGE_SHIFT;

  logic [AW:0]        wr_lo, wr_hi, pg_lo, pg_hi;
  logic               chk_en;
  logic [NCORE-1:0]   set_vec, clr_vec, pg_hit_vec;
  logic [NCORE*AW-1:0] rng_lo_flat, rng_hi_flat;
  logic [CW-1:0]      cnt;

  always_comb begin
    chk_en = (cnt != '0);
    wr_lo  = {1'b0, wr_addr};
    wr_hi  = wr_lo + (AW+1)'(wr_len);
    pg_lo  = {1'b0, pg_addr[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    pg_hi  = pg_lo + PAGE_SPAN;
  end

  for (genvar g = 0; g < NCORE; g++) begin : g_slot
    wrw_slot #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .setup_vld  (setup_vld[g]),
      .setup_addr (setup_addr[g*AW +: AW]),
      .arm        (arm_req[g]),
      .disarm     (disarm_req[g]),
      .chk_en     (chk_en),
      .wr_vld     (wr_vld),
      .wr_lo      (wr_lo),
      .wr_hi      (wr_hi),
      .pg_lo      (pg_lo),
      .pg_hi      (pg_hi),
      .active     (mon_active_o[g]),
      .set_ev     (set_vec[g]),
      .clr_ev     (clr_vec[g]),
      .wake       (wake_o[g]),
      .clr_pulse  (mon_clr_o[g]),
      .pg_hit     (pg_hit_vec[g]),
      .rng_lo     (rng_lo_flat[g*AW +: AW]),
      .rng_hi     (rng_hi_flat[g*AW +: AW])
    );
  end

  wrw_count #(.NCORE(NCORE), .CW(CW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .cnt     (cnt)
  );

  assign active_cnt_o = cnt;
  assign pg_veto_o    = pg_wr & (|pg_hit_vec);

endmodule

// File: rtl/wr_range_watch_chk.sv
module wr_range_watch_chk #(
  parameter int NCORE = 4,
  parameter int AW    = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NCORE-1:0]           wake,
  input logic [NCORE-1:0]           clr,
  input logic [NCORE-1:0]           act,
  input logic [$clog2(NCORE+1)-1:0] cnt,
  input logic                       pg_wr,
  input logic                       pg_veto,
  input logic [NCORE*AW-1:0]        lo_flat,
  input logic [NCORE*AW-1:0]        hi_flat
);

  // R5
  wake_has_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake & ~clr) == '0);

  // R5
  woken_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake & act) == '0);

  // R4
  cnt_tracks_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) == 32'($countones(act)));

  // R6
  idle_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |=> (wake == '0));

  // R8
  read_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_wr |-> !pg_veto);

  for (genvar g = 0; g < NCORE; g++) begin : g_rng
    // R2
    range_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act[g] |-> (hi_flat[g*AW +: AW] >= lo_flat[g*AW +: AW]));
  end

endmodule

bind wr_range_watch wr_range_watch_chk #(.NCORE(NCORE), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wake    (wake_o),
  .clr     (mon_clr_o),
  .act     (mon_active_o),
  .cnt     (active_cnt_o),
  .pg_wr   (pg_wr),
  .pg_veto (pg_veto_o),
  .lo_flat (rng_lo_flat),
  .hi_flat (rng_hi_flat)
);

// File: tb/wr_range_watch_tb.sv
`timescale 1ns/1ps
module wr_range_watch_tb;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int LW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    setup_vld = '0, arm_req = '0, disarm_req = '0;
  logic [N*AW-1:0] setup_addr = '0;
  logic            wr_vld = 1'b0, pg_wr = 1'b0;
  logic [AW-1:0]   wr_addr = '0, pg_addr = '0;
  logic [LW-1:0]   wr_len = '0;
  logic [N-1:0]    wake_o, mon_clr_o, mon_active_o;
  logic [2:0]      active_cnt_o;
  logic            pg_veto_o;

  always #2.5 clk = ~clk;

  wr_range_watch #(.NCORE(N), .AW(AW), .LENW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .setup_vld(setup_vld), .setup_addr(setup_addr),
    .arm_req(arm_req), .disarm_req(disarm_req), .wr_vld(wr_vld), .wr_addr(wr_addr),
    .wr_len(wr_len), .pg_addr(pg_addr), .pg_wr(pg_wr), .wake_o(wake_o),
    .mon_clr_o(mon_clr_o), .mon_active_o(mon_active_o), .active_cnt_o(active_cnt_o),
    .pg_veto_o(pg_veto_o)
  );

  typedef struct {
    logic [N-1:0] wake, clr, act;
    int           cnt;
    string        tag;
  } exp_t;

  exp_t          sb_q[$];
  int            n_run = 0, n_fail = 0;
  bit            done = 1'b0;
  logic [AW-1:0] m_lo[N], m_hi[N], su_a[N];
  logic [N-1:0]  m_act = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the predicted outcome
  task automatic cyc(input logic [N-1:0] su, input logic [N-1:0] ar, input logic [N-1:0] ds,
                     input logic wv, input int wa, input int wl, input string tag);
    exp_t e;
    @(negedge clk);
    setup_vld = su; arm_req = ar; disarm_req = ds;
    wr_vld = wv; wr_addr = AW'(wa); wr_len = LW'(wl);
    for (int i = 0; i < N; i++) setup_addr[i*AW +: AW] = su_a[i];
    e.wake = '0; e.clr = '0; e.tag = tag;
    for (int i = 0; i < N; i++) begin
      bit hit, c, s;
      hit = m_act[i] && wv && !((wa >= int'(m_hi[i])) || (wa + wl <= int'(m_lo[i])));
      c   = m_act[i] && (hit || ds[i]);
      s   = !m_act[i] && ar[i] && !ds[i] && (m_lo[i] != m_hi[i]);
      e.wake[i] = hit;
      e.clr[i]  = c;
      e.act[i]  = c ? 1'b0 : (m_act[i] | s);
      if (su[i]) begin
        m_lo[i] = su_a[i];
        m_hi[i] = su_a[i] + AW'(64);
      end
    end
    m_act = e.act;
    e.cnt = $countones(e.act);
    @(posedge clk);
    sb_q.push_back(e);
    #0.5;
    setup_vld = '0; arm_req = '0; disarm_req = '0; wr_vld = 1'b0;
  endtask

  task automatic pgq(input int a, input logic w, input logic exp, input string tag);
    @(negedge clk);
    pg_addr = AW'(a); pg_wr = w;
    #1;
    chk(pg_veto_o == exp, tag, int'(pg_veto_o), int'(exp));
    pg_wr = 1'b0;
  endtask

  // monitor: pops predictions as registered results appear
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(wake_o == e.wake, {e.tag, " wake"}, int'(wake_o), int'(e.wake));
      chk(mon_clr_o == e.clr, {e.tag, " clr"}, int'(mon_clr_o), int'(e.clr));
      chk(mon_active_o == e.act, {e.tag, " active"}, int'(mon_active_o), int'(e.act));
      chk(int'(active_cnt_o) == e.cnt, {e.tag, " count"}, int'(active_cnt_o), e.cnt);
    end
  end

  initial begin
    #500000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_lo[i] = '1; m_hi[i] = '1; su_a[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(wake_o == '0 && mon_clr_o == '0, "R1 reset pulses", int'({wake_o, mon_clr_o}), 0);
    chk(mon_active_o == '0, "R1 reset active", int'(mon_active_o), 0);
    chk(active_cnt_o == '0, "R1 reset count", int'(active_cnt_o), 0);
    pgq('hFFFF, 1'b1, 1'b0, "R1 reset veto");
    cyc('0, 4'hF, '0, 0, 0, 0, "R1 arm before setup");

    su_a[0] = 16'h1000; su_a[1] = 16'h1040; su_a[2] = 16'h1020; su_a[3] = 16'h8000;
    cyc(4'hF, '0, '0, 0, 0, 0, "R2 setup all");
    cyc('0, 4'b0111, '0, 0, 0, 0, "R4 arm three");
    cyc('0, 4'b0001, '0, 0, 0, 0, "R4 rearm no count");
    cyc('0, '0, '0, 1, 'h0FFF, 1, "R3 touch below begin");
    cyc('0, '0, '0, 1, 'h0FFF, 2, "R5 overlap wake");
    cyc('0, '0, '0, 1, 'h1040, 1, "R9 two cores wake");
    cyc('0, '0, '0, 1, 'h1000, 64, "R6 count zero no wake");

    cyc('0, 4'b1001, 4'b1000, 0, 0, 0, "R7 disarm beats arm");
    cyc('0, '0, '0, 1, 'h8000, 4, "R6 unarmed core");
    cyc('0, '0, '0, 1, 'h1040, 4, "R3 end exclusive");
    cyc('0, '0, '0, 1, 'h103F, 1, "R5 last byte wake");

    cyc('0, 4'b1000, '0, 0, 0, 0, "R4 arm page core");
    pgq('h8FFF, 1'b1, 1'b1, "R8 write veto");
    pgq('h8FFF, 1'b0, 1'b0, "R8 read passes");
    pgq('h9000, 1'b1, 1'b0, "R8 next page");
    pgq('h7FFF, 1'b1, 1'b0, "R8 prev page");
    cyc('0, '0, 4'b1000, 0, 0, 0, "R7 disarm clear");
    pgq('h8000, 1'b1, 1'b0, "R8 no veto after disarm");

    cyc('0, 4'b0010, '0, 0, 0, 0, "R4 arm core1");
    su_a[1] = 16'h2000;
    cyc(4'b0010, '0, '0, 0, 0, 0, "R2 setup while armed");
    cyc('0, '0, '0, 1, 'h1040, 1, "R2 old range gone");
    cyc('0, '0, '0, 1, 'h2010, 16, "R2 new range wake");

    su_a[2] = 16'hFF80;
    cyc(4'b0100, '0, '0, 0, 0, 0, "R2 setup top");
    cyc('0, 4'b0100, '0, 0, 0, 0, "R4 arm top");
    cyc('0, '0, '0, 1, 'hFFF0, 32, "R3 past end no wrap");
    cyc('0, '0, '0, 1, 'hFFBF, 'h80, "R3 carry write wake");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule